// File: doc/BRIEF.md
# Dual-Tone DDS Generator

This block makes the digital test signal for one DAC channel by direct digital synthesis. It runs two sine tones, each with its own phase accumulator, frequency step, start phase and signed amplitude scale. On every clock it sums the two scaled tones into one 16-bit signed sample. A tone's output frequency is `step × f_clk / 2^PHASE_DW`.

The phase width `PHASE_DW` is a synthesis parameter from 16 to 32 bits, and the block reports it on a 6-bit output so that software can work out the steps. Each step and start phase arrives as two 16-bit words. The low word holds phase bits 15:0 and the extension word holds the bits above them. A disable input parks the generator and forces silence. A sync input restarts both tones together, so that their start phases take effect again from a known point.

Top module: `dual_tone_dds`

## Requirements
- R1: `phase_dw_o` carries the value of `PHASE_DW` as a 6-bit unsigned number.
- R2: A tone's step is `{incr_hi, incr_lo}` cut to `PHASE_DW` bits, with the low word in bits 15:0. While the block is enabled and no sync is given, the tone's accumulator adds its step modulo 2^PHASE_DW on every clock.
- R3: A tone's start phase is formed from `{init_hi, init_lo}` in the same way. It is added modulo 2^PHASE_DW to the accumulator before the sine lookup.
- R4: The lookup address `a` is the top 10 bits of the offset phase. The tone value is round(32767·sin(2π(a+0.5)/1024)), accurate to 1 LSB, and comes from a quarter-wave table that is built inside the block.
- R5: A scale is a 16-bit two's-complement number with 14 fractional bits, so 0x4000 means 1.0 and 0xC000 means −1.0. Each scaled tone is floor(tone·scale / 2^14).
- R6: The sample is the sum of the two scaled tones. A sum above 32767 gives 0x7FFF and a sum below −32768 gives 0x8000. Two full-scale tones at gain 0x4000 therefore saturate and do not wrap.
- R7: The accumulator, the tone value and the sample are each registered. A change of a start phase reaches `sample_o` at the second rising edge after it is applied, and a change of a scale reaches it at the first.
- R8: While `dds_off_i` is high, every edge clears both accumulators, both tone values and `sample_o`. Step, start-phase and scale inputs then have no effect on the output. Once `dds_off_i` is released, each tone restarts from its start phase.
- R9: A high `sync_i` on an edge clears both accumulators to zero on that edge. Sync has no further effect while the block is disabled.
- R10: While `rst_ni` is low, `sample_o` and both accumulators are zero.
- R11: Extension-word bits at position `PHASE_DW−16` and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dds_off_i | input | 1 | Disable: forces silence and parks both accumulators |
| sync_i | input | 1 | Restart both accumulators at zero |
| t1_incr_lo_i | input | 16 | Tone 1 step, phase bits 15:0 |
| t1_incr_hi_i | input | 16 | Tone 1 step, phase bits above 15 |
| t1_init_lo_i | input | 16 | Tone 1 start phase, bits 15:0 |
| t1_init_hi_i | input | 16 | Tone 1 start phase, bits above 15 |
| t1_scale_i | input | 16 | Tone 1 amplitude, signed, 14 fractional bits |
| t2_incr_lo_i | input | 16 | Tone 2 step, phase bits 15:0 |
| t2_incr_hi_i | input | 16 | Tone 2 step, phase bits above 15 |
| t2_init_lo_i | input | 16 | Tone 2 start phase, bits 15:0 |
| t2_init_hi_i | input | 16 | Tone 2 start phase, bits above 15 |
| t2_scale_i | input | 16 | Tone 2 amplitude, signed, 14 fractional bits |
| phase_dw_o | output | 6 | Phase accumulator width |
| sample_o | output | 16 | Summed, saturated output sample, signed |

## Verification
Sync and disable can arrive on the same edge. Sync can also arrive while both tones are running with large, non-commensurate steps. The bench pulses sync in the middle of a disabled stretch and again during normal running. It then compares every cycle against a behavioural model built on real-valued sine arithmetic, and checks that the output stays exactly zero until release and then restarts from the start phases. Saturation and the two-stage latency are judged together. A start-phase jump from the positive peak to the negative peak at gain 1.0 must move `sample_o` from 0x7FFF to 0x8000, exactly at the second edge after the jump.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int unsigned SMP_W    = 16;
  localparam int unsigned SCL_FRAC = 14;
  localparam longint      AMP      = 64'sd32767;
  localparam longint      ONE_Q30  = 64'sd1 <<< 30;
  localparam longint      HPI_Q30  = 64'sd1686629713;  // pi/2 in Q30

  typedef logic [SMP_W-1:0] smp_t;

  // Positive quarter-wave entry k of 2^qaw, sampled at bin centres (Taylor series, Q30)
  function automatic smp_t qtr_sine(input int unsigned k, input int unsigned qaw);
    longint x;
    longint x2;
    longint term;
    longint acc_s;
    x     = (HPI_Q30 * longint'(2 * k + 1)) / (64'sd1 <<< (qaw + 1));
    x2    = (x * x) / ONE_Q30;
    term  = x;
    acc_s = x;
    for (int n = 1; n <= 7; n++) begin
      term  = -((term * x2) / ONE_Q30) / longint'((2 * n) * (2 * n + 1));
      acc_s = acc_s + term;
    end
    return smp_t'((acc_s * AMP + (ONE_Q30 >>> 1)) / ONE_Q30);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned PHASE_DW = 24,
  parameter int unsigned LUT_AW   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                off_i,
  input  logic                sync_i,
  input  logic [15:0]         incr_lo_i,
  input  logic [15:0]         incr_hi_i,
  input  logic [15:0]         init_lo_i,
  input  logic [15:0]         init_hi_i,
  output logic [PHASE_DW-1:0] acc_o,
  output logic [LUT_AW-1:0]   addr_o
);

  localparam int unsigned DROP = PHASE_DW - LUT_AW;

  logic [PHASE_DW-1:0] step_w;
  logic [PHASE_DW-1:0] start_w;

  // extension word supplies bits PHASE_DW-1:16; anything above is cut off
  assign step_w  = PHASE_DW'({incr_hi_i, incr_lo_i});
  assign start_w = PHASE_DW'({init_hi_i, init_lo_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
    end else if (off_i || sync_i) begin
      acc_o <= '0;
    end else begin
      acc_o <= acc_o + step_w;
    end
  end

  assign addr_o = LUT_AW'((acc_o + start_w) >> DROP);

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int unsigned LUT_AW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 off_i,
  input  logic [LUT_AW-1:0]    addr_i,
  output logic [dds_pkg::SMP_W-1:0] sine_o
);

  localparam int unsigned SMP_W = dds_pkg::SMP_W;
  localparam int unsigned QAW   = LUT_AW - 2;
  localparam int unsigned QN    = 1 << QAW;

  logic [SMP_W-1:0] qtab [QN];
  logic [QAW-1:0]   qidx;
  logic [SMP_W-1:0] mag;

  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam logic [SMP_W-1:0] VAL = dds_pkg::qtr_sine(k, QAW);
    assign qtab[k] = VAL;
  end

  // quadrants 1 and 3 read the quarter backwards, quadrants 2 and 3 negate
  assign qidx = addr_i[QAW] ? ~addr_i[QAW-1:0] : addr_i[QAW-1:0];
  assign mag  = qtab[qidx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sine_o <= '0;
    end else if (off_i) begin
      sine_o <= '0;
    end else begin
      sine_o <= addr_i[LUT_AW-1] ? -mag : mag;
    end
  end

endmodule

// File: rtl/dds_mix.sv
module dds_mix #(
  parameter int unsigned NT = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               off_i,
  input  logic [NT-1:0][dds_pkg::SMP_W-1:0]  sine_i,
  input  logic [NT-1:0][dds_pkg::SMP_W-1:0]  scale_i,
  output logic [dds_pkg::SMP_W-1:0]          sample_o
);

  localparam int unsigned SMP_W    = dds_pkg::SMP_W;
  localparam int unsigned SCL_FRAC = dds_pkg::SCL_FRAC;
  localparam int unsigned PROD_W   = 2 * SMP_W;
  localparam int unsigned SUM_W    = PROD_W - SCL_FRAC + $clog2(NT);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((2 ** (SMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S = ~MAX_S;

  logic signed [SUM_W-1:0] sum_c;
  logic [SMP_W-1:0]        sat_c;

  always_comb begin
    sum_c = '0;
    for (int t = 0; t < NT; t++) begin
      sum_c = sum_c + SUM_W'(($signed(PROD_W'($signed(sine_i[t]))) *
                              $signed(PROD_W'($signed(scale_i[t])))) >>> SCL_FRAC);
    end
  end

  always_comb begin
    if (sum_c > MAX_S) begin
      sat_c = MAX_S[SMP_W-1:0];
    end else if (sum_c < MIN_S) begin
      sat_c = MIN_S[SMP_W-1:0];
    end else begin
      sat_c = sum_c[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
    end else if (off_i) begin
      sample_o <= '0;
    end else begin
      sample_o <= sat_c;
    end
  end

endmodule

// File: rtl/dual_tone_dds.sv
module dual_tone_dds #(
  parameter int unsigned PHASE_DW = 24,
  parameter int unsigned LUT_AW   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dds_off_i,
  input  logic        sync_i,
  input  logic [15:0] t1_incr_lo_i,
  input  logic [15:0] t1_incr_hi_i,
  input  logic [15:0] t1_init_lo_i,
  input  logic [15:0] t1_init_hi_i,
  input  logic [15:0] t1_scale_i,
  input  logic [15:0] t2_incr_lo_i,
  input  logic [15:0] t2_incr_hi_i,
  input  logic [15:0] t2_init_lo_i,
  input  logic [15:0] t2_init_hi_i,
  input  logic [15:0] t2_scale_i,
  output logic [5:0]  phase_dw_o,
  output logic [15:0] sample_o
);

  localparam int unsigned NT    = 2;
  localparam int unsigned SMP_W = dds_pkg::SMP_W;

  logic [NT-1:0][15:0]         incr_lo;
  logic [NT-1:0][15:0]         incr_hi;
  logic [NT-1:0][15:0]         init_lo;
  logic [NT-1:0][15:0]         init_hi;
  logic [NT-1:0][SMP_W-1:0]    scale;
  logic [NT-1:0][PHASE_DW-1:0] phase_acc;
  logic [NT-1:0][LUT_AW-1:0]   lut_addr;
  logic [NT-1:0][SMP_W-1:0]    sine;

  assign incr_lo = {t2_incr_lo_i, t1_incr_lo_i};
  assign incr_hi = {t2_incr_hi_i, t1_incr_hi_i};
  assign init_lo = {t2_init_lo_i, t1_init_lo_i};
  assign init_hi = {t2_init_hi_i, t1_init_hi_i};
  assign scale   = {t2_scale_i,   t1_scale_i};

  for (genvar t = 0; t < NT; t++) begin : g_tone
    dds_phase_acc #(
      .PHASE_DW (PHASE_DW),
      .LUT_AW   (LUT_AW)
    ) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .off_i     (dds_off_i),
      .sync_i    (sync_i),
      .incr_lo_i (incr_lo[t]),
      .incr_hi_i (incr_hi[t]),
      .init_lo_i (init_lo[t]),
      .init_hi_i (init_hi[t]),
      .acc_o     (phase_acc[t]),
      .addr_o    (lut_addr[t])
    );

    dds_sine_lut #(
      .LUT_AW (LUT_AW)
    ) u_lut (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .off_i  (dds_off_i),
      .addr_i (lut_addr[t]),
      .sine_o (sine[t])
    );
  end

  dds_mix #(
    .NT (NT)
  ) u_mix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .off_i    (dds_off_i),
    .sine_i   (sine),
    .scale_i  (scale),
    .sample_o (sample_o)
  );

  assign phase_dw_o = 6'(PHASE_DW);

endmodule

// File: rtl/dual_tone_dds_chk.sv
module dual_tone_dds_chk #(
  parameter int unsigned PHASE_DW = 24
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     dds_off_i,
  input logic                     sync_i,
  input logic [15:0]              t1_incr_lo_i,
  input logic [15:0]              t1_incr_hi_i,
  input logic [15:0]              t2_incr_lo_i,
  input logic [15:0]              t2_incr_hi_i,
  input logic [1:0][PHASE_DW-1:0] phase_acc,
  input logic [15:0]              sample_o
);

  logic [PHASE_DW-1:0] step1;
  logic [PHASE_DW-1:0] step2;

  assign step1 = PHASE_DW'({t1_incr_hi_i, t1_incr_lo_i});
  assign step2 = PHASE_DW'({t2_incr_hi_i, t2_incr_lo_i});

  // R8
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_off_i |=> sample_o == 16'h0000);

  // R8
  off_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_off_i |=> phase_acc == '0);

  // R9
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> phase_acc == '0);

  // R2
  step1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dds_off_i && !sync_i) |=> phase_acc[0] == PHASE_DW'($past(phase_acc[0]) + $past(step1)));

  // R2
  step2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dds_off_i && !sync_i) |=> phase_acc[1] == PHASE_DW'($past(phase_acc[1]) + $past(step2)));

endmodule

bind dual_tone_dds dual_tone_dds_chk #(
  .PHASE_DW (PHASE_DW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dds_off_i    (dds_off_i),
  .sync_i       (sync_i),
  .t1_incr_lo_i (t1_incr_lo_i),
  .t1_incr_hi_i (t1_incr_hi_i),
  .t2_incr_lo_i (t2_incr_lo_i),
  .t2_incr_hi_i (t2_incr_hi_i),
  .phase_acc    (phase_acc),
  .sample_o     (sample_o)
);

// File: tb/dual_tone_dds_bench.sv
module dual_tone_dds_bench;

  localparam int CLK_P = 10;
  localparam int PW    = 24;
  localparam int LAW   = 10;
  localparam int TOL   = 6;
  localparam longint unsigned MASK = (64'd1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dds_off = 1'b0;
  logic sync = 1'b0;
  logic [15:0] t1_il = '0, t1_ih = '0, t1_pl = '0, t1_ph = '0, t1_sc = '0;
  logic [15:0] t2_il = '0, t2_ih = '0, t2_pl = '0, t2_ph = '0, t2_sc = '0;
  logic [5:0]  phase_dw;
  logic [15:0] sample;

  int checks = 0;
  int errs = 0;

  always #(CLK_P / 2) clk = ~clk;

  dual_tone_dds #(.PHASE_DW(PW), .LUT_AW(LAW)) u_dual_tone_dds (
    .clk_i(clk), .rst_ni(rst_n), .dds_off_i(dds_off), .sync_i(sync),
    .t1_incr_lo_i(t1_il), .t1_incr_hi_i(t1_ih), .t1_init_lo_i(t1_pl),
    .t1_init_hi_i(t1_ph), .t1_scale_i(t1_sc),
    .t2_incr_lo_i(t2_il), .t2_incr_hi_i(t2_ih), .t2_init_lo_i(t2_pl),
    .t2_init_hi_i(t2_ph), .t2_scale_i(t2_sc),
    .phase_dw_o(phase_dw), .sample_o(sample)
  );

  // reference model
  longint unsigned m_acc1 = 0, m_acc2 = 0;
  int m_sin1 = 0, m_sin2 = 0, m_out = 0;

  function automatic int ref_sin(input longint unsigned ph);
    int  a;
    real w;
    a = int'((ph & MASK) >> (PW - LAW));
    w = 32767.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / real'(1 << LAW));
    return int'(w);
  endfunction

  function automatic longint unsigned word(input logic [15:0] hi, input logic [15:0] lo);
    return longint'({hi, lo}) & MASK;  // R11: upper extension bits dropped
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc1 = 0; m_acc2 = 0; m_sin1 = 0; m_sin2 = 0; m_out = 0;
    end else if (dds_off) begin
      m_acc1 = 0; m_acc2 = 0; m_sin1 = 0; m_sin2 = 0; m_out = 0;
    end else begin
      int s;
      s = ((m_sin1 * int'($signed(t1_sc))) >>> 14) + ((m_sin2 * int'($signed(t2_sc))) >>> 14);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      m_out  = s;
      m_sin1 = ref_sin(m_acc1 + word(t1_ph, t1_pl));
      m_sin2 = ref_sin(m_acc2 + word(t2_ph, t2_pl));
      if (sync) begin
        m_acc1 = 0; m_acc2 = 0;
      end else begin
        m_acc1 = (m_acc1 + word(t1_ih, t1_il)) & MASK;
        m_acc2 = (m_acc2 + word(t2_ih, t2_il)) & MASK;
      end
    end
  end

  task automatic cmp(input string tag);
    int act, d;
    act = int'($signed(sample));
    d = act - m_out;
    if (d < 0) d = -d;
    checks++;
    if (d > TOL) begin
      errs++;
      $display("FAIL %s: sample=%0d expected=%0d", tag, act, m_out);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    #(CLK_P / 4);
    cmp(tag);
  endtask

  task automatic exact(input string tag, input logic [15:0] exp);
    checks++;
    if (sample !== exp) begin
      errs++;
      $display("FAIL %s: sample=%h expected=%h", tag, sample, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_P + 3);
    // R10: reset state
    exact("R10", 16'h0000);
    // R1: width report
    checks++;
    if (phase_dw !== 6'(PW)) begin
      errs++;
      $display("FAIL R1: phase_dw=%0d expected=%0d", phase_dw, PW);
    end
    rst_n = 1'b1;

    // R2 R4 R5 R6: two running tones with extended steps
    t1_il = 16'h1000; t1_ih = 16'h0001; t1_sc = 16'h2000;
    t2_il = 16'h3456; t2_ih = 16'h0002; t2_ph = 16'h0030; t2_sc = 16'h1800;
    repeat (300) cyc("R2 R4 R5 R6");

    // R3 R9: new start phases applied through a sync pulse
    t1_ph = 16'h0055; t1_pl = 16'h1234;
    sync = 1'b1;
    cyc("R9");
    sync = 1'b0;
    repeat (100) cyc("R3 R9");

    // R11: garbage in unused extension bits
    t1_ih = 16'hAB01; t2_ph = 16'hFF30;
    repeat (100) cyc("R11");

    // R6 R7: over-range at unity gain, then peak-to-trough jump
    t1_il = '0; t1_ih = '0; t2_il = '0; t2_ih = '0;
    t1_pl = '0; t2_pl = '0; t1_ph = 16'h0040; t2_ph = 16'h0040;
    t1_sc = 16'h4000; t2_sc = 16'h4000;
    sync = 1'b1;
    cyc("R6");
    sync = 1'b0;
    repeat (3) cyc("R6");
    exact("R6", 16'h7FFF);
    t1_ph = 16'h00C0; t2_ph = 16'h00C0;
    cyc("R7");
    exact("R7", 16'h7FFF);
    cyc("R7");
    exact("R6 R7", 16'h8000);
    // R5: negative unity scale on the trough, one-edge scale latency
    t1_sc = 16'hC000; t2_sc = 16'hC000;
    cyc("R5");
    exact("R5 R6", 16'h7FFF);
    t1_sc = 16'h4000;
    repeat (3) cyc("R5");

    // R8: disable with live settings, sync pulsed inside
    t1_il = 16'h2222; t1_ih = 16'h0003; t1_pl = 16'h0100; t1_ph = 16'h0011; t1_sc = 16'h3000;
    t2_il = 16'h0777; t2_ih = 16'h0001; t2_pl = 16'h0000; t2_ph = 16'h0090; t2_sc = 16'hE000;
    repeat (20) cyc("R8");
    dds_off = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i == 5) sync = 1'b1;
      if (i == 6) sync = 1'b0;
      if (i == 3) t1_sc = 16'h7FFF;
      cyc("R8");
      exact("R8", 16'h0000);
    end
    dds_off = 1'b0;
    repeat (80) cyc("R8 R3");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule